// File: doc/BRIEF.md
# Random Word Status and Interrupt Controller

This block is the software-facing control and status logic of a random number generator. It takes finished 32-bit random words from an upstream source over a valid/ready handshake. It collects them into sets of four and flags a set as ready once the fourth word arrives. Software then reads the four words one at a time through a data register. The ready flag clears itself when the fourth word has been read.

Two error inputs, one for seed faults and one for clock faults, set sticky flags. Software clears the clock flag by writing zero to it. It clears the seed flag the same way, or by pulsing a conditioning-reset control bit high and then low. While that reset bit is high, the word buffer is flushed and refuses input.

A single registered interrupt line combines the three flags. The line is qualified by an interrupt enable bit and a run bit, and it stays low whenever the block is not running.

Top module: `rng_irq_ctrl`

## Requirements
- R1: After reset, the control register (address 0) and the status register (address 1) read 0, `irq` is 0 and `word_ready` is 0.
- R2: The control register holds run in bit 0, interrupt enable in bit 1 and conditioning reset in bit 2. A write stores these bits and a read returns them.
- R3: `word_ready` is 1 only when run is 1, conditioning reset is 0 and no complete set is being held. A word is taken on a clock edge when `word_valid` and `word_ready` are both 1.
- R4: Status bit 0 (ready) becomes 1 after the edge that takes the fourth word of a set, and stays 0 while fewer than four words are held.
- R5: A read of the data register (address 2) while ready is 1 returns the held words in arrival order, one per read. Ready falls after the fourth read. A data read while ready is 0 returns 0 and removes nothing.
- R6: A pulse on `seed_err_evt` sets status bit 1, and a pulse on `clk_err_evt` sets status bit 2, whether or not run is set.
- R7: A status write with 0 in bit 1 or bit 2 clears that flag. A 1 in those bits has no effect, and bit 0 of a status write is ignored.
- R8: An error event in the same cycle as a clearing status write leaves the flag set.
- R9: A control write that takes conditioning reset from 1 to 0 clears the seed flag and leaves the clock flag unchanged.
- R10: While conditioning reset is 1, the buffered words are discarded and no new word is taken. The next set read afterwards holds only words that arrived after the reset was released.
- R11: `irq` is a register. Each cycle it takes the value of interrupt enable AND run AND (ready OR seed flag OR clock flag) from the previous cycle, so it is 0 whenever run is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register index: 0 control, 1 status, 2 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| word_valid | input | 1 | Upstream word valid |
| word_data | input | 32 | Upstream random word |
| word_ready | output | 1 | Block can take a word |
| seed_err_evt | input | 1 | Seed fault event pulse |
| clk_err_evt | input | 1 | Clock fault event pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a collision, where an error event lands in the same clock cycle as the register write that would clear its flag. The bench drives the event pulse and the clearing status write on the same falling edge, so both are seen by the same rising edge. It then checks that the flag survives. The conditioning-reset flush is reached in a similar way. The bench part-fills a set, toggles the reset bit, and then loads a fresh set. Reading that set back shows whether the earlier words were discarded. The interrupt is swept over every combination of run, enable and error source.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2
  } reg_sel_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_CRST = 2;

  localparam int STAT_RDY  = 0;
  localparam int STAT_SEED = 1;
  localparam int STAT_CLK  = 2;
endpackage

// File: rtl/rng_set_buf.sv
module rng_set_buf #(
  parameter int WORD_W    = 32,
  parameter int SET_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_ok,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  output logic [WORD_W-1:0] out_data,
  output logic              set_ready
);
  localparam int PTR_W = $clog2(SET_WORDS);
  localparam int CNT_W = $clog2(SET_WORDS + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(SET_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SET_WORDS - 1);

  logic [WORD_W-1:0] mem_q [SET_WORDS];
  logic [CNT_W-1:0]  fill_q, fill_d;
  logic [PTR_W-1:0]  rd_q, rd_d;
  logic              full_q, full_d;
  logic              take;

  assign in_ready = in_ok && !full_q && !flush;
  assign take     = in_valid && in_ready;

  always_comb begin
    fill_d = fill_q;
    rd_d   = rd_q;
    full_d = full_q;
    if (flush) begin
      fill_d = '0;
      rd_d   = '0;
      full_d = 1'b0;
    end else if (full_q) begin
      if (pop) begin
        if (rd_q == LAST_PTR) begin
          rd_d   = '0;
          fill_d = '0;
          full_d = 1'b0;
        end else begin
          rd_d = rd_q + 1'b1;
        end
      end
    end else if (take) begin
      fill_d = fill_q + 1'b1;
      if (fill_q == LAST_CNT) full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else begin
      fill_q <= fill_d;
      rd_q   <= rd_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem_q[fill_q[PTR_W-1:0]] <= in_data;
  end

  assign out_data  = full_q ? mem_q[rd_q] : '0;
  assign set_ready = full_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(SET_WORDS)) else $error("fill count overflow"); // R3
  AST_LAST_POP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && pop && rd_q == LAST_PTR) |=> !full_q) else $error("ready held after last pop"); // R5
  AST_FULL_AFTER_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fill_q == LAST_CNT && !flush) |=> full_q) else $error("set not marked ready"); // R4
endmodule

// File: rtl/rng_err_flags.sv
module rng_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_evt,
  input  logic clk_evt,
  input  logic stat_wr,
  input  logic wr_seed_bit,
  input  logic wr_clk_bit,
  input  logic cond_fall,
  output logic seed_err,
  output logic clk_err
);
  logic seed_q, seed_d, clk_q, clk_d;
  logic seed_clr, clk_clr;

  assign seed_clr = (stat_wr && !wr_seed_bit) || cond_fall;
  assign clk_clr  = stat_wr && !wr_clk_bit;

  always_comb begin
    seed_d = seed_evt || (seed_q && !seed_clr);
    clk_d  = clk_evt  || (clk_q  && !clk_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      seed_q <= seed_d;
      clk_q  <= clk_d;
    end
  end

  assign seed_err = seed_q;
  assign clk_err  = clk_q;

  AST_SEED_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    seed_evt |=> seed_err) else $error("seed event lost"); // R8
  AST_CLK_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clk_evt |=> clk_err) else $error("clock event lost"); // R6
  AST_CLK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_err && !(stat_wr && !wr_clk_bit)) |=> clk_err) else $error("clock flag dropped"); // R9
endmodule

// File: rtl/rng_irq_ctrl.sv
module rng_irq_ctrl
  import rng_irq_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SET_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  input  logic              seed_err_evt,
  input  logic              clk_err_evt,
  output logic              irq
);
  logic run_q, run_d, ie_q, ie_d, crst_q, crst_d, irq_q, irq_d;
  logic ctrl_wr, stat_wr, data_rd;
  logic set_ready, seed_err, clk_err;
  logic [WORD_W-1:0] buf_data;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata[WORD_W-1:3];

  assign ctrl_wr = bus_sel && bus_wr  && (bus_addr == REG_CTRL);
  assign stat_wr = bus_sel && bus_wr  && (bus_addr == REG_STAT);
  assign data_rd = bus_sel && !bus_wr && (bus_addr == REG_DATA);

  always_comb begin
    run_d  = run_q;
    ie_d   = ie_q;
    crst_d = crst_q;
    if (ctrl_wr) begin
      run_d  = bus_wdata[CTRL_RUN];
      ie_d   = bus_wdata[CTRL_IE];
      crst_d = bus_wdata[CTRL_CRST];
    end
    irq_d = run_q && ie_q && (set_ready || seed_err || clk_err);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      crst_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      ie_q   <= ie_d;
      crst_q <= crst_d;
      irq_q  <= irq_d;
    end
  end

  rng_set_buf #(.WORD_W(WORD_W), .SET_WORDS(SET_WORDS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (crst_q),
    .in_ok     (run_q),
    .in_valid  (word_valid),
    .in_data   (word_data),
    .in_ready  (word_ready),
    .pop       (data_rd),
    .out_data  (buf_data),
    .set_ready (set_ready)
  );

  rng_err_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_evt    (seed_err_evt),
    .clk_evt     (clk_err_evt),
    .stat_wr     (stat_wr),
    .wr_seed_bit (bus_wdata[STAT_SEED]),
    .wr_clk_bit  (bus_wdata[STAT_CLK]),
    .cond_fall   (crst_q && !crst_d),
    .seed_err    (seed_err),
    .clk_err     (clk_err)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CTRL_RUN]  = run_q;
        bus_rdata[CTRL_IE]   = ie_q;
        bus_rdata[CTRL_CRST] = crst_q;
      end
      REG_STAT: begin
        bus_rdata[STAT_RDY]  = set_ready;
        bus_rdata[STAT_SEED] = seed_err;
        bus_rdata[STAT_CLK]  = clk_err;
      end
      REG_DATA: bus_rdata = buf_data;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = irq_q;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run_q && ie_q)) else $error("irq while gated off"); // R11
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    crst_q |=> !set_ready) else $error("set survived flush"); // R10
  AST_NO_TAKE_IN_CRST: assert property (@(posedge clk) disable iff (!rst_n)
    crst_q |-> !word_ready) else $error("accepting during flush"); // R10
endmodule

// File: tb/rng_irq_ctrl_test.sv
module rng_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        word_valid;
  logic [31:0] word_data;
  logic        word_ready;
  logic        seed_err_evt, clk_err_evt;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rng_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .seed_err_evt(seed_err_evt), .clk_err_evt(clk_err_evt), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    chk("R3 word_ready before push", {31'd0, word_ready}, 32'd1);
    word_valid = 1'b1; word_data = d;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int s, input int i);
    return 32'h1000_0000 * (s + 1) ^ (32'h0101_0101 * (i + 3)) ^ (32'hFFFF_0000 >> s);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    word_valid = 0; word_data = 0; seed_err_evt = 0; clk_err_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 stat", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 word_ready", {31'd0, word_ready}, 0);

    // R2 control readback
    wr(2'd0, 32'hFFFF_FFFB);
    rd(2'd0, v); chk("R2 ctrl readback", v, 32'd3);
    chk("R3 ready when running", {31'd0, word_ready}, 1);

    // R4 R5 three sets with distinct patterns
    for (int s = 0; s < 3; s++) begin
      for (int i = 0; i < 4; i++) begin
        push(pat(s, i));
        rd(2'd1, v);
        chk("R4 ready bit", {31'd0, v[0]}, (i == 3) ? 32'd1 : 32'd0);
      end
      chk("R3 no room while set held", {31'd0, word_ready}, 0);
      chk("R11 irq on ready", {31'd0, irq}, 1);
      for (int i = 0; i < 4; i++) begin
        rd(2'd2, v); chk("R5 word order", v, pat(s, i));
      end
      rd(2'd1, v); chk("R5 ready fell", {31'd0, v[0]}, 0);
      rd(2'd2, v); chk("R5 empty data read", v, 0);
      chk("R11 irq dropped", {31'd0, irq}, 0);
    end

    // R6 R7 with run cleared
    wr(2'd0, 32'd0);
    @(negedge clk); seed_err_evt = 1; @(negedge clk); seed_err_evt = 0;
    rd(2'd1, v); chk("R6 seed flag", v, 32'd2);
    chk("R11 no irq when stopped", {31'd0, irq}, 0);
    wr(2'd1, 32'h7);
    rd(2'd1, v); chk("R7 write one no effect", v, 32'd2);
    @(negedge clk); clk_err_evt = 1; @(negedge clk); clk_err_evt = 0;
    rd(2'd1, v); chk("R6 clock flag", v, 32'd6);
    wr(2'd1, 32'h5);
    rd(2'd1, v); chk("R7 seed cleared only", v, 32'd4);
    wr(2'd1, 32'h3);
    rd(2'd1, v); chk("R7 clock cleared", v, 32'd0);

    // R8 collision: event with clearing write
    @(negedge clk);
    seed_err_evt = 1; clk_err_evt = 1;
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 32'd0;
    @(negedge clk);
    seed_err_evt = 0; clk_err_evt = 0; bus_sel = 0; bus_wr = 0;
    rd(2'd1, v); chk("R8 event beats clear", v, 32'd6);

    // R9 conditioning reset toggle
    wr(2'd0, 32'd4);
    rd(2'd1, v); chk("R9 seed held while high", v, 32'd6);
    wr(2'd0, 32'd0);
    rd(2'd1, v); chk("R9 toggle clears seed only", v, 32'd4);
    wr(2'd1, 32'd0);

    // R10 flush
    wr(2'd0, 32'd1);
    push(32'hDEAD_0001); push(32'hDEAD_0002);
    wr(2'd0, 32'd5);
    chk("R10 no accept in reset", {31'd0, word_ready}, 0);
    wr(2'd0, 32'd1);
    for (int i = 0; i < 4; i++) push(pat(7, i));
    for (int i = 0; i < 4; i++) begin
      rd(2'd2, v); chk("R10 only fresh words", v, pat(7, i));
    end

    // R11 sweep of run, enable and error source
    for (int r = 0; r < 2; r++)
      for (int e = 0; e < 2; e++)
        for (int src = 0; src < 2; src++) begin
          wr(2'd0, {30'd0, e[0], r[0]});
          @(negedge clk);
          if (src == 0) seed_err_evt = 1; else clk_err_evt = 1;
          @(negedge clk);
          seed_err_evt = 0; clk_err_evt = 0;
          @(negedge clk);
          chk("R11 irq sweep", {31'd0, irq}, {31'd0, r[0] & e[0]});
          wr(2'd1, 32'd0);
          @(negedge clk);
          chk("R11 irq after clear", {31'd0, irq}, 0);
        end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule